// File: doc/BRIEF.md
# Sample Event Buffer with Hysteretic Stop Flag

This block is the per-section sample store that sits between zero-suppression and readout. Zero-suppressed samples arrive on a write strobe while acquisition is enabled. They leave in arrival order through a valid/ready port while readout is enabled. The whole block runs on one clock, and the slow sample rate and fast readout rate are expressed as strobes. The default store holds 4096 twelve-bit samples, which is enough for one full-depth event of about three thousand samples.

When the store fills up, a stop flag goes high and new samples are refused. The flag stays high until the occupancy has fallen to a quarter of the depth, that is, until the store is three-quarters empty. Samples that are offered and refused are counted in a saturating drop counter.

Two enable inputs select one of four operating modes. A rising edge on the acquisition enable resynchronises acquisition and empties the store.

Top module: `evt_buffer`

## Requirements
- R1: The `mode` output reports the enables as the pair {acq_en, rdo_en}: 2'b00 is configuration (idle), 2'b10 is acquire only, 2'b11 is acquire with concurrent readout, and 2'b01 is readout only.
- R2: A sample is stored when `in_valid` and `acq_en` are both high, the stop flag is low and the store is not full. Stored samples are read back in the order they were written.
- R3: `level` equals the number of samples held, from 0 up to 2^ADDR_W.
- R4: The stop flag `full_flag` rises on the clock edge that follows a cycle in which `level` equals the depth.
- R5: Once high, `full_flag` stays high while `level` is above depth/4. It falls on the edge after a cycle in which `level` is at or below depth/4.
- R6: A sample offered with `acq_en` high but not stored increments `drop_cnt`. The counter saturates at all ones.
- R7: While `acq_en` is low, `in_valid` has no effect: nothing is stored and `drop_cnt` does not change.
- R8: `out_valid` equals `rdo_en` and (`level` > 0). A sample is removed on a cycle where `out_valid` and `out_ready` are both high. `out_data` shows the oldest sample.
- R9: In a cycle where `acq_en` is high and was low in the previous cycle:
  - the store is emptied, `full_flag` is cleared and `drop_cnt` is cleared;
  - any sample offered in that cycle is discarded without being counted;
  - `out_valid` is low.
- R10: After reset, `level` is 0, `full_flag` is low, `drop_cnt` is 0 and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_en | input | 1 | Acquisition enable; a rising edge flushes the store |
| rdo_en | input | 1 | Readout enable |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W (12) | Sample value |
| out_ready | input | 1 | Consumer accepts the presented sample |
| out_valid | output | 1 | A sample is presented |
| out_data | output | DATA_W (12) | Oldest stored sample |
| full_flag | output | 1 | Hysteretic stop flag |
| level | output | ADDR_W+1 (13) | Stored sample count |
| drop_cnt | output | DROP_W (16) | Saturating count of refused samples |
| mode | output | 2 | Decoded operating mode |

## Verification
The bench uses a depth-8 store with a 4-bit drop counter.

It first fills the store with continuous writes and no reads. This shows that storage stops at exactly the depth and that surplus samples are counted rather than stored. Next it reads and writes together at full rate. This separates a flag that clears at depth/4 from one that clears as soon as space appears.

Readout-only and configuration phases show that writes are ignored when acquisition is off, and that `out_valid` drops at empty. A long refused stream drives the drop counter into saturation.

Finally, a long pseudo-random mix of enables, strobes and back-pressure exercises the mode changes, and acquisition restarts mid-stream to exercise the flush.

// File: rtl/evt_buf_pkg.sv
package evt_buf_pkg;

  typedef enum logic [1:0] {
    MODE_CFG  = 2'b00,
    MODE_RDO  = 2'b01,
    MODE_ACQ  = 2'b10,
    MODE_BOTH = 2'b11
  } evt_mode_e;

  // Mode is the enable pair taken as a two-bit code.
  function automatic evt_mode_e decode_mode(input logic acq, input logic rdo);
    return evt_mode_e'({acq, rdo});
  endfunction

  // Occupancy at or below which acquisition may resume (three-quarters empty).
  function automatic int unsigned resume_mark(input int unsigned depth);
    return depth / 4;
  endfunction

  // Occupancy from two wrap-extended pointers.
  function automatic int unsigned ptr_gap(input int unsigned wp, input int unsigned rp,
                                          input int unsigned ptr_w);
    return (wp - rp) & ((1 << ptr_w) - 1);
  endfunction

endpackage

// File: rtl/evt_mode_decode.sv
module evt_mode_decode
  import evt_buf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      acq_en,
  input  logic      rdo_en,
  output evt_mode_e mode,
  output logic      sync_pulse
);
  logic acq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acq_q <= 1'b0;
    else        acq_q <= acq_en;
  end

  assign sync_pulse = acq_en & ~acq_q;
  assign mode       = decode_mode(acq_en, rdo_en);

  // R9
  sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);
endmodule

// File: rtl/evt_ring_store.sv
module evt_ring_store
  import evt_buf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W:0]   level
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PTR_W = ADDR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr[ADDR_W-1:0]] <= wdata;
  end

  assign rdata = mem[rd_ptr[ADDR_W-1:0]];
  assign level = PTR_W'(ptr_gap(32'(wr_ptr), 32'(rd_ptr), PTR_W));

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= PTR_W'(DEPTH));
  // R3
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && push && !pop) |=> level == $past(level) + 1'b1);
endmodule

// File: rtl/evt_fill_guard.sv
module evt_fill_guard
  import evt_buf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic              offer,
  input  logic [ADDR_W:0]   level,
  output logic              wr_accept,
  output logic              full_flag,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam int LW     = ADDR_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [LW-1:0] FULL_LVL   = LW'(DEPTH);
  localparam logic [LW-1:0] RESUME_LVL = LW'(resume_mark(DEPTH));

  logic drop_evt;

  assign wr_accept = offer & ~sync & ~full_flag & (level != FULL_LVL);
  assign drop_evt  = offer & ~sync & ~wr_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_flag <= 1'b0;
      drop_cnt  <= '0;
    end else if (sync) begin
      full_flag <= 1'b0;
      drop_cnt  <= '0;
    end else begin
      if (!full_flag && level == FULL_LVL)      full_flag <= 1'b1;
      else if (full_flag && level <= RESUME_LVL) full_flag <= 1'b0;
      if (drop_evt && drop_cnt != '1) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !full_flag && level == FULL_LVL) |=> full_flag);
  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && full_flag && level > RESUME_LVL) |=> full_flag);
  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_flag) |-> ($past(sync) || $past(level) <= RESUME_LVL));
  // R2
  no_write_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_flag |-> !wr_accept);
  // R6
  drop_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && drop_cnt == '1) |=> drop_cnt == '1);
endmodule

// File: rtl/evt_buffer.sv
module evt_buffer
  import evt_buf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12,
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_en,
  input  logic              rdo_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              full_flag,
  output logic [ADDR_W:0]   level,
  output logic [DROP_W-1:0] drop_cnt,
  output logic [1:0]        mode
);
  evt_mode_e mode_e;
  logic      sync_pulse;
  logic      wr_accept;
  logic      rd_take;
  logic      offer;

  evt_mode_decode u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .acq_en     (acq_en),
    .rdo_en     (rdo_en),
    .mode       (mode_e),
    .sync_pulse (sync_pulse)
  );

  assign offer = in_valid & acq_en;

  evt_fill_guard #(.ADDR_W(ADDR_W), .DROP_W(DROP_W)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync      (sync_pulse),
    .offer     (offer),
    .level     (level),
    .wr_accept (wr_accept),
    .full_flag (full_flag),
    .drop_cnt  (drop_cnt)
  );

  assign out_valid = rdo_en & ~sync_pulse & (level != '0);
  assign rd_take   = out_valid & out_ready;

  evt_ring_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (sync_pulse),
    .push  (wr_accept),
    .wdata (in_data),
    .pop   (rd_take),
    .rdata (out_data),
    .level (level)
  );

  assign mode = mode_e;

  // R8
  valid_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (level != '0 && rdo_en));
  // R7
  idle_acq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acq_en && !sync_pulse) |=> drop_cnt == $past(drop_cnt));
  // R9
  flush_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> (level == '0 && !full_flag && drop_cnt == '0));
endmodule

// File: tb/sim_evt_buffer.sv
module sim_evt_buffer;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int D  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acq_en = 1'b0, rdo_en = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid, full_flag;
  logic [DW-1:0] out_data;
  logic [AW:0]   level;
  logic [CW-1:0] drop_cnt;
  logic [1:0]    mode;

  int  n_cmp = 0, n_bad = 0;
  bit  done = 0;
  string phase = "R10 reset";

  int  q[$];
  bit  m_flag = 0, m_ae_q = 0;
  int  m_drops = 0;

  always #4 clk = ~clk;

  evt_buffer #(.ADDR_W(AW), .DATA_W(DW), .DROP_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .rdo_en(rdo_en),
    .in_valid(in_valid), .in_data(in_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .full_flag(full_flag),
    .level(level), .drop_cnt(drop_cnt), .mode(mode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit ae, input bit re, input bit iv, input int dv, input bit rdy);
    bit sync, ev, push, pop;
    int sz;
    @(negedge clk);
    acq_en = ae; rdo_en = re; in_valid = iv; in_data = DW'(dv); out_ready = rdy;
    #1;
    sync = ae & ~m_ae_q;
    sz   = q.size();
    ev   = re & ~sync & (sz != 0);
    chk("R1 mode", int'(mode), int'({ae, re}));
    chk("R3 level", int'(level), sz);
    chk("R4/R5 flag", int'(full_flag), int'(m_flag));
    chk("R8 valid", int'(out_valid), int'(ev));
    chk("R6 drops", int'(drop_cnt), m_drops);
    if (ev) chk("R2 data", int'(out_data), q[0]);
    if (sync) begin
      q.delete(); m_flag = 0; m_drops = 0;
    end else begin
      push = iv & ae & ~m_flag & (sz < D);
      pop  = ev & rdy;
      if (!m_flag && sz == D) m_flag = 1;
      else if (m_flag && sz <= D / 4) m_flag = 0;
      if (iv && ae && !push && m_drops < (1 << CW) - 1) m_drops++;
      if (pop) void'(q.pop_front());
      if (push) q.push_back(dv & ((1 << DW) - 1));
    end
    m_ae_q = ae;
  endtask

  initial begin
    int d = 1;
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: state right after reset
    cyc(0, 0, 0, 0, 0);
    // R2 R4 R6: fill without reads, flag rises, surplus counted; first cycle is a sync (R9)
    phase = "R4 fill";
    repeat (14) begin cyc(1, 0, 1, d, 0); d++; end
    // R5 R8: concurrent read/write, flag holds until level <= D/4
    phase = "R5 drain+write";
    repeat (14) begin cyc(1, 1, 1, d, 1); d++; end
    // R7 R8: readout only, writes ignored, valid falls at empty
    phase = "R7 readout only";
    repeat (14) begin cyc(0, 1, 1, d, 1); d++; end
    // R7: configuration mode
    phase = "R7 config";
    repeat (4) begin cyc(0, 0, 1, d, 1); d++; end
    // R6: long refused stream saturates the counter
    phase = "R6 saturate";
    repeat (30) begin cyc(1, 0, 1, d, 0); d++; end
    // R9: restart acquisition clears counter and store
    phase = "R9 restart";
    cyc(0, 0, 0, 0, 0);
    cyc(1, 1, 1, d, 1); d++;
    cyc(1, 1, 0, 0, 1);
    // mixed pseudo-random traffic
    phase = "R2 mixed";
    for (int i = 0; i < 1500; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[9] | lf[8] | lf[7], lf[3] | lf[11], lf[0] | lf[5], int'(lf[15:8]), lf[2] & lf[6]);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog [%s] actual=running expected=done", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule